// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Encoder

This block takes octets from a 2.048 Mbit/s PCM time-slot and sends them out again as a continuous 64 kbit/s codirectional bipolar stream. The stream uses two active-low rails. Incoming bits are shifted in during a strobe window. Two strobe inputs are provided, and a select level decides which one opens the window. Each complete octet is placed in a single holding latch. The output side takes the octet from that latch whenever the previous octet has finished transmitting.

Every data bit is sent as a block of four symbol intervals. A one is mark-mark-space-space and a zero is mark-space-mark-space. Each block takes the opposite polarity from the block before it, except for the last block of an octet. That block keeps the same polarity as the block before it, and this deliberate violation marks the octet boundary. An alarm input suppresses the violation.

The two clock domains drift slightly against each other, and the block absorbs this by slipping whole octets:
- If no new octet is waiting when one finishes, the last octet is sent once more, and after that the line goes quiet.
- If a second octet arrives before the first has been taken from the latch, it overwrites the first.

The whole block runs on one system clock. Single-cycle enables stand in for the 2.048 MHz edge and the 256 kHz edge.

Top module: `codir_encoder`

## Requirements
- R1: When `slot_sel` is 1, `slot_a` is the capture strobe, and when it is 0, `slot_b` is. Bits presented under the strobe that is not selected are ignored and queue nothing.
- R2: On each cycle where `tx2m_en` is 1 and the selected strobe is 1, one bit of `pcm_in` is captured. Eight captures form one octet. The first bit captured is the first bit transmitted.
- R3: Each `tx256k_en` pulse advances the line by one symbol interval. Within a block, a one is sent as mark, mark, space, space and a zero as mark, space, mark, space.
- R4: Successive blocks alternate polarity. The first block sent after reset is positive, which means `line_pos_n` is driven low on its marks.
- R5: The eighth block of every octet repeats the polarity of the seventh block (a violation). The first block of the next octet then takes the opposite polarity.
- R6: If `alarm_in` is 1 at the pulse that begins the eighth block, no violation is inserted and that block takes the opposite polarity, like any other.
- R7: Both rails are active-low. A mark drives only the rail of the current polarity low. Both rails are high during a space and while idle. The two rails are never low together.
- R8: When an octet finishes and the latch holds a new octet, the new octet starts on the very next interval, with no gap.
- R9: When an octet finishes and no new octet is waiting, that octet is sent exactly once more. After the repeat, both rails stay high until a new octet arrives.
- R10: An octet that completes while the latch is still full replaces the latch contents, and the older octet is never sent.
- R11: After reset both rails are high and no octet is queued.
- R12: The rails change only in the cycle after a `tx256k_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx2m_en | input | 1 | One-cycle enable marking a 2.048 MHz capture edge |
| tx256k_en | input | 1 | One-cycle enable marking a 256 kHz line interval |
| slot_a | input | 1 | First time-slot strobe |
| slot_b | input | 1 | Second time-slot strobe |
| slot_sel | input | 1 | Strobe select: 1 selects slot_a, 0 selects slot_b |
| pcm_in | input | 1 | Serial PCM data |
| alarm_in | input | 1 | Suppresses the octet-boundary violation while 1 |
| line_pos_n | output | 1 | Positive-polarity mark rail, active low |
| line_neg_n | output | 1 | Negative-polarity mark rail, active low |

## Verification
The assertions assume the following about the inputs:
- Each enable is a single-cycle pulse, and no enable arrives during reset.
- A strobe window spans exactly eight `tx2m_en` pulses.
- `alarm_in` does not toggle inside an octet.

The stimulus keeps within these assumptions. Capture bursts and line intervals are issued from separate tasks and never overlap in the same cycle. The alarm level is set before an octet starts and held until it ends. A polarity model in the bench runs independently of the design and predicts every symbol interval, including the repeat and the quiet line that follows it.

// File: rtl/codir_encoder.sv
module codir_encoder #(
  parameter int OCT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx2m_en,
  input  logic tx256k_en,
  input  logic slot_a,
  input  logic slot_b,
  input  logic slot_sel,
  input  logic pcm_in,
  input  logic alarm_in,
  output logic line_pos_n,
  output logic line_neg_n
);
  localparam int BW = $clog2(OCT_W);
  localparam logic [BW-1:0] LAST = BW'(OCT_W - 1);
  localparam logic [BW-1:0] PENULT = BW'(OCT_W - 2);

  logic [OCT_W-2:0] in_sr;
  logic [BW-1:0]    in_cnt;
  logic [OCT_W-1:0] latch_q, cur_q;
  logic             latch_full, repeat_ok, active, last_neg;
  logic [BW-1:0]    bit_idx;
  logic [1:0]       phase;

  logic strobe, cap, in_done;
  logic [OCT_W-1:0] in_next;
  assign strobe  = slot_sel ? slot_a : slot_b;
  assign cap     = tx2m_en && strobe;
  assign in_done = cap && (in_cnt == LAST);
  assign in_next = {in_sr, pcm_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr  <= '0;
      in_cnt <= '0;
    end else if (tx2m_en && !strobe) begin
      in_cnt <= '0;
    end else if (cap) begin
      in_sr  <= in_next[OCT_W-2:0];
      in_cnt <= in_done ? '0 : in_cnt + BW'(1);
    end
  end

  logic oct_end, need, take, resend, keep_pol;
  assign oct_end  = (phase == 2'd3) && (bit_idx == LAST);
  assign need     = tx256k_en && (!active || oct_end);
  assign take     = need && latch_full;
  assign resend   = need && !latch_full && active && repeat_ok;
  assign keep_pol = (bit_idx == PENULT) && !alarm_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '0;
      latch_full <= 1'b0;
    end else begin
      if (in_done) latch_q <= in_next;
      if (in_done)   latch_full <= 1'b1;
      else if (take) latch_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      repeat_ok <= 1'b0;
      active    <= 1'b0;
      last_neg  <= 1'b1;
      bit_idx   <= '0;
      phase     <= '0;
    end else if (tx256k_en) begin
      if (need) begin
        phase   <= '0;
        bit_idx <= '0;
        if (take) begin
          cur_q     <= latch_q;
          repeat_ok <= 1'b1;
          active    <= 1'b1;
          last_neg  <= ~last_neg;
        end else if (resend) begin
          repeat_ok <= 1'b0;
          last_neg  <= ~last_neg;
        end else begin
          active <= 1'b0;
        end
      end else begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) begin
          bit_idx <= bit_idx + BW'(1);
          if (!keep_pol) last_neg <= ~last_neg;
        end
      end
    end
  end

  logic cur_bit, mark;
  assign cur_bit    = cur_q[LAST - bit_idx];
  assign mark       = active && (cur_bit ? ~phase[1] : ~phase[0]);
  assign line_pos_n = ~(mark && !last_neg);
  assign line_neg_n = ~(mark && last_neg);
endmodule

// File: rtl/codir_encoder_chk.sv
module codir_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx2m_en,
  input logic       tx256k_en,
  input logic       line_pos_n,
  input logic       line_neg_n,
  input logic       latch_full,
  input logic       active,
  input logic [1:0] phase
);
  assert_rails_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_pos_n || line_neg_n);

  assert_rails_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx256k_en) |-> ($stable(line_pos_n) && $stable(line_neg_n)));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx256k_en) |-> $stable(phase));

  assert_fill_on_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_full) |-> $past(tx2m_en));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (line_pos_n && line_neg_n));

  assert_idle_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !$past(latch_full));
endmodule

bind codir_encoder codir_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx2m_en(tx2m_en), .tx256k_en(tx256k_en),
  .line_pos_n(line_pos_n), .line_neg_n(line_neg_n),
  .latch_full(latch_full), .active(active), .phase(phase)
);

// File: tb/sim_codir_encoder.sv
module sim_codir_encoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx2m_en = 0, tx256k_en = 0, slot_a = 0, slot_b = 0, slot_sel = 0;
  logic pcm_in = 0, alarm_in = 0;
  logic line_pos_n, line_neg_n;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  bit exp_neg = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  codir_encoder u0 (
    .clk(clk), .rst_n(rst_n), .tx2m_en(tx2m_en), .tx256k_en(tx256k_en),
    .slot_a(slot_a), .slot_b(slot_b), .slot_sel(slot_sel), .pcm_in(pcm_in),
    .alarm_in(alarm_in), .line_pos_n(line_pos_n), .line_neg_n(line_neg_n)
  );

  task automatic check(input logic [1:0] got, input logic [1:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: rails(pos_n,neg_n) got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); tx256k_en = 1'b1;
    @(negedge clk); tx256k_en = 1'b0;
  endtask

  task automatic load_octet(input logic [7:0] val, input logic sel, input logic use_a);
    @(negedge clk);
    slot_sel = sel;
    slot_a = use_a; slot_b = !use_a;
    for (int i = 0; i < 8; i++) begin
      pcm_in = val[7-i]; tx2m_en = 1'b1;
      @(negedge clk);
    end
    tx2m_en = 1'b0; slot_a = 0; slot_b = 0; pcm_in = 0;
  endtask

  task automatic expect_octet(input logic [7:0] val, input bit mid, input logic [7:0] mid_val,
                              input string tag);
    for (int blk = 0; blk < 8; blk++) begin
      if (!(blk == 7 && !alarm_in)) exp_neg = !exp_neg;
      for (int ph = 0; ph < 4; ph++) begin
        bit mk;
        if (mid && blk == 3 && ph == 0) load_octet(mid_val, 1'b1, 1'b1);
        tick();
        mk = val[7-blk] ? (ph < 2) : (ph % 2 == 0);
        check({line_pos_n, line_neg_n}, {!(mk && !exp_neg), !(mk && exp_neg)}, tag);
      end
    end
  endtask

  task automatic expect_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      check({line_pos_n, line_neg_n}, 2'b11, tag);
    end
  endtask

  task automatic t_reset();
    check({line_pos_n, line_neg_n}, 2'b11, "R11 reset rails");
    expect_idle(6, "R11 nothing queued");
  endtask

  task automatic t_unselected();
    load_octet(8'h00, 1'b0, 1'b1);
    expect_idle(8, "R1 unselected strobe ignored");
    load_octet(8'h00, 1'b1, 1'b0);
    expect_idle(8, "R1 unselected strobe ignored");
  endtask

  task automatic t_basic();
    load_octet(8'h96, 1'b1, 1'b1);
    expect_octet(8'h96, 0, 8'h00, "R2 R3 R4 R5 R7 first octet");
    expect_octet(8'h96, 0, 8'h00, "R9 repeat once");
    expect_idle(10, "R9 quiet after repeat");
  endtask

  task automatic t_slot_b();
    load_octet(8'h3C, 1'b0, 1'b0);
    expect_octet(8'h3C, 0, 8'h00, "R1 slot_b capture");
    expect_octet(8'h3C, 0, 8'h00, "R9 repeat once");
    expect_idle(6, "R9 quiet after repeat");
  endtask

  task automatic t_alarm();
    alarm_in = 1'b1;
    load_octet(8'hA5, 1'b1, 1'b1);
    expect_octet(8'hA5, 0, 8'h00, "R6 no violation");
    expect_octet(8'hA5, 0, 8'h00, "R6 no violation repeat");
    expect_idle(4, "R9 quiet");
    alarm_in = 1'b0;
  endtask

  task automatic t_chain();
    load_octet(8'h5A, 1'b1, 1'b1);
    expect_octet(8'h5A, 1, 8'hC3, "R5 octet with mid load");
    expect_octet(8'hC3, 0, 8'h00, "R8 seamless handoff");
    expect_octet(8'hC3, 0, 8'h00, "R9 repeat once");
    expect_idle(6, "R9 quiet");
  endtask

  task automatic t_overwrite();
    load_octet(8'h11, 1'b1, 1'b1);
    load_octet(8'hE7, 1'b0, 1'b0);
    expect_octet(8'hE7, 0, 8'h00, "R10 newer octet wins");
    expect_octet(8'hE7, 0, 8'h00, "R10 R9 repeat of newer");
    expect_idle(6, "R10 older octet never sent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unselected();
    t_basic();
    t_slot_b();
    t_alarm();
    t_chain();
    t_overwrite();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R12: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule